// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between a clocked system and an asynchronous byte-wide static RAM with a 15-bit address. The system side offers one request at a time through a valid/ready handshake. The memory side gets active-low chip select, write enable and output enable, a registered address bus, and a split data bus (`mem_dq_out`, `mem_dq_oe`, `mem_dq_in`) that a pad ring joins into one tri-state bus.

Every strobe phase lasts a whole number of clock cycles. Each phase length is computed at elaboration from a nanosecond timing parameter and the clock period, rounded up, with a floor of one cycle. The memory's minimum timing rules therefore hold at any clock rate the parameters describe. Output enable stays inactive for the whole of every write. Because of this the short write-pulse rule applies, and the memory never drives the bus while the controller does.

Back-pressure: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the access, including any recovery slot, is finished. A requester holding `req_valid` high while `req_ready` is low is simply kept waiting. The read response has no back-pressure: `rsp_valid` is a single-cycle pulse, and the requester must take `rsp_rdata` in that cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted only on a rising edge with `req_valid` = 1 and `req_ready` = 1 (`req_write` = 1 selects a write, 0 a read). `req_ready` then stays 0 for RD + 1 cycles after a read and PW + 2 cycles after a write.
- R3: A read drives `mem_cs_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 for exactly RD cycles with `mem_addr` stable. RD = max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)).
- R4: Read data is sampled from `mem_dq_in` on the edge that ends the last read cycle. It is returned on `rsp_rdata` with `rsp_valid` = 1 in the cycle that follows, and it equals the byte last written to that address.
- R5: A write holds `mem_cs_n` = 0 for PW + 2 cycles: one setup cycle, PW cycles with `mem_we_n` = 0, and one hold cycle. `mem_we_n` is never 0 while `mem_cs_n` is 1. PW = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS) + 1, ceil(T_WC_NS/CLK_NS) - 2).
- R6: `mem_oe_n` is 1 in every cycle of a write.
- R7: `mem_dq_oe` is 1 only from the cycle after `mem_we_n` falls through the cycle after it rises. Data is therefore driven for at least ceil(T_DW_NS/CLK_NS) cycles before the end of the write and held one cycle past it.
- R8: After every read, one cycle with all strobes at 1 follows before any other access. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, nor in the cycle right after one with `mem_oe_n` = 0.
- R9: Every phase length is the rounded-up cycle count of its nanosecond parameter and is at least one cycle. With the bench values (10 ns clock, 20/20/15/11/20 ns), RD = 2 and PW = 3.
- R10: `rsp_valid` is 1 for exactly one cycle per read and is never 1 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data to drive onto the shared bus |
| mem_dq_oe | output | 1 | Drive enable for the shared bus |
| mem_dq_in | input | DATA_W | Data sensed from the shared bus |

## Verification
The bench builds the controller with a 6-bit address, 8-bit data, a 10 ns clock and the 20 ns grade figures, which gives RD = 2 and PW = 3. The small address space lets every location be written and read back in two passes with different data patterns, one of them interleaving a write and a read of each address, so every read-to-write turnaround gets exercised. The bench's memory model returns a poison byte until the read strobes have been steady for RD cycles, which exposes a capture one cycle early. The model commits a write at the edge where the write strobe ends, so the pulse length, the length of data drive and the hold cycle are all measured against the arithmetic values.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSET   = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } seq_state_e;

  // cycles needed to cover ns at a clock period of clk_ns, at least one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int PW_CYC = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_zero,
  output seq_state_e       state,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_run,
  output logic             rd_done,
  output logic             drive_q
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(PW_CYC - 1);

  seq_state_e state_q, state_d;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign rd_done = (state_q == ST_READ) && cnt_zero;
  assign cnt_run = (state_q == ST_READ) || (state_q == ST_WPULSE);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_WSET;
          end else begin
            state_d  = ST_READ;
            cnt_load = 1'b1;
            cnt_val  = RD_LOAD;
          end
        end
      end
      ST_READ:   if (cnt_zero) state_d = ST_TURN;
      ST_TURN:   state_d = ST_IDLE;
      ST_WSET: begin
        state_d  = ST_WPULSE;
        cnt_load = 1'b1;
        cnt_val  = PW_LOAD;
      end
      ST_WPULSE: if (cnt_zero) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // bus drive trails the write strobe by one cycle on both edges
      drive_q <= (state_q == ST_WPULSE);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic              accept,
  input  logic              rd_done,
  input  logic              drive_q,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= rd_done;
      if (rd_done) rdata_q <= mem_dq_in;
    end
  end

  // strobes decode straight from state flops
  always_comb begin
    mem_cs_n = 1'b1;
    mem_we_n = 1'b1;
    mem_oe_n = 1'b1;
    unique case (state)
      ST_READ: begin
        mem_cs_n = 1'b0;
        mem_oe_n = 1'b0;
      end
      ST_WSET, ST_WHOLD: mem_cs_n = 1'b0;
      ST_WPULSE: begin
        mem_cs_n = 1'b0;
        mem_we_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drive_q;
  assign rsp_valid  = rvld_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 20,
  parameter int T_RC_NS = 20,
  parameter int T_WP_NS = 15,
  parameter int T_DW_NS = 11,
  parameter int T_WC_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int PW_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                    ns_to_cyc(T_DW_NS, CLK_NS) + 1),
                               imax(ns_to_cyc(T_WC_NS, CLK_NS) - 2, 1));
  localparam int CNT_W  = $clog2(imax(RD_CYC, PW_CYC) + 1);

  seq_state_e       state;
  logic             accept, cnt_load, cnt_run, cnt_zero, rd_done, drive_q;
  logic [CNT_W-1:0] cnt_val;

  asram_seq #(.RD_CYC(RD_CYC), .PW_CYC(PW_CYC), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .cnt_zero (cnt_zero),
    .state    (state),
    .accept   (accept),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .cnt_run  (cnt_run),
    .rd_done  (rd_done),
    .drive_q  (drive_q)
  );

  asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .run     (cnt_run),
    .zero    (cnt_zero)
  );

  asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (accept),
    .rd_done   (rd_done),
    .drive_q   (drive_q),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

  assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_we_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_oe_off_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_lags_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  p_drive_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_cs_n && !mem_dq_oe));

  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  function automatic int cdiv(input int ns, input int ck);
    int c;
    c = (ns + ck - 1) / ck;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP = mx(cdiv(20, 10), cdiv(20, 10));
  localparam int DS_EXP = cdiv(11, 10);
  localparam int PW_EXP = mx(mx(cdiv(15, 10), DS_EXP + 1), mx(cdiv(20, 10) - 2, 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(10), .T_AA_NS(20), .T_RC_NS(20),
               .T_WP_NS(15), .T_DW_NS(11), .T_WC_NS(20)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model, updated at the falling edge
  logic [DW-1:0] mem [DEPTH];
  int  rd_age = 0;
  int  we_low = 0, drv_cnt = 0;
  bit  wr_prev = 0, oe_prev_low = 0;
  logic [AW-1:0] age_addr = '0;

  assign mem_dq_in = (rd_age >= RD_EXP) ? mem[mem_addr] : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n)
        rd_age <= (rd_age > 0 && age_addr == mem_addr) ? rd_age + 1 : 1;
      else
        rd_age <= 0;
      age_addr <= mem_addr;
      if (mem_dq_oe && (!mem_oe_n || oe_prev_low))
        chk("R8 drive with output enable", 0, mem_oe_n, 1);
      if (!mem_we_n && !mem_oe_n)
        chk("R6 oe low in write", 0, mem_oe_n, 1);
      if (!mem_we_n && mem_cs_n)
        chk("R5 we without cs", 0, mem_cs_n, 0);
      if (!mem_cs_n && !mem_we_n) begin
        if (we_low == 0) chk("R7 drive starts late", !mem_dq_oe, mem_dq_oe, 0);
        we_low  <= we_low + 1;
        drv_cnt <= drv_cnt + (mem_dq_oe ? 1 : 0);
        wr_prev <= 1;
      end else if (wr_prev) begin
        chk("R5 pulse length", we_low == PW_EXP, we_low, PW_EXP);
        chk("R7 data setup cycles", drv_cnt >= DS_EXP, drv_cnt, DS_EXP);
        chk("R7 hold drive", mem_dq_oe == 1'b1, mem_dq_oe, 1);
        chk("R5 cs held in hold", !mem_cs_n, mem_cs_n, 0);
        mem[mem_addr] = mem_dq_out;
        we_low  <= 0;
        drv_cnt <= 0;
        wr_prev <= 0;
      end else if (mem_dq_oe) begin
        chk("R7 stray drive", 0, mem_dq_oe, 0);
      end
      oe_prev_low <= !mem_oe_n;
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int busy, output int ridx, output int rcnt,
                      output logic [DW-1:0] rd, output bit turn_ok);
    int guard = 0;
    busy = 0; ridx = 0; rcnt = 0; rd = '0; turn_ok = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      if (guard == 0) req_valid = 0;
      if (rsp_valid) begin
        rcnt++; ridx = guard + 1; rd = rsp_rdata;
        turn_ok = mem_cs_n && mem_oe_n && mem_we_n;
      end
      if (!req_ready) busy++;
      guard++;
    end while (!req_ready && guard < 50);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return DW'(((a * 13 + p * 7) << 1) | 1);
  endfunction

  task automatic do_write(input int a, input int p);
    int busy, ridx, rcnt; logic [DW-1:0] rd; bit t;
    xfer(1, AW'(a), pat(a, p), busy, ridx, rcnt, rd, t);
    chk("R2 write busy", busy == PW_EXP + 2, busy, PW_EXP + 2);
    chk("R10 no rsp on write", rcnt == 0, rcnt, 0);
  endtask

  task automatic do_read(input int a, input int p);
    int busy, ridx, rcnt; logic [DW-1:0] rd; bit t;
    xfer(0, AW'(a), 8'h00, busy, ridx, rcnt, rd, t);
    chk("R2 read busy", busy == RD_EXP + 1, busy, RD_EXP + 1);
    chk("R3 rsp timing", ridx == RD_EXP + 1, ridx, RD_EXP + 1);
    chk("R10 one rsp", rcnt == 1, rcnt, 1);
    chk("R4 read data", rd == pat(a, p), rd, pat(a, p));
    chk("R8 turnaround slot", t, t, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", mem_cs_n, mem_cs_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cs_n", mem_cs_n == 1, mem_cs_n, 1);
    chk("R1 we_n", mem_we_n == 1, mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n == 1, mem_oe_n, 1);
    chk("R1 dq_oe", mem_dq_oe == 0, mem_dq_oe, 0);
    chk("R1 ready", req_ready == 1, req_ready, 1);
    chk("R1 rsp_valid", rsp_valid == 0, rsp_valid, 0);
    chk("R9 phase counts", RD_EXP == 2 && PW_EXP == 3, RD_EXP * 10 + PW_EXP, 23);
    for (int a = 0; a < DEPTH; a++) do_write(a, 0);
    for (int a = 0; a < DEPTH; a++) do_read(a, 0);
    for (int a = DEPTH - 1; a >= 0; a--) begin
      do_write(a, 1);
      do_read(a, 1);
    end
    for (int a = 0; a < DEPTH; a += 5) do_read(a, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule